// File: doc/BRIEF.md
# Fractional-Rate Realtime Counter

This block keeps a free-running 64-bit time count that advances at a fixed average rate, whatever the frequency of the system clock that drives it. It does this with a fractional incrementer. On every system clock the numerator is added to an accumulator. When the sum reaches the denominator, the denominator is subtracted and the count steps by one. The average count rate is therefore the clock rate times numerator over denominator. For a 6.144 MHz target, the pair is chosen per system clock. Examples: 4/25 at 38.4 MHz, 64/125 at 12 MHz, 768/1625 at 13 MHz. When the slow reference is derived as the system clock divided by 610, the pair 75/244 is used.

Software programs the pair through a small register port. The two words sit at byte offsets 0x10 (numerator) and 0x14 (denominator). Only the low 12 bits of each word feed the incrementer. The upper 20 bits are stored as written and read back unchanged, so a read-modify-write keeps them.

An external correction tick, standing in for a slow reference clock, clears the fractional residue so that the next step phase is realigned to the tick.

Top module: `rfc_counter`

## Requirements
- R1: During and after a synchronous active-high reset the count is 0. After reset the numerator word reads 4 and the denominator word reads 25, the 38.4 MHz setting.
- R2: With a nonzero denominator field D and a numerator field N below it, the count advances by exactly N over any D consecutive clocks.
- R3: The count never decreases and advances by at most one per clock.
- R4: While the denominator field (bits 11:0 of the word at 0x14) is zero, the count holds its value.
- R5: While the denominator field is nonzero and the numerator field (bits 11:0 of the word at 0x10) is greater than or equal to it, the count advances by one on every clock.
- R6: Both words are 32 bits wide. Writing a word stores all 32 bits, and reading it returns them. Only bits 11:0 set the rate. Reads return data one clock after the address is presented. Any other offset reads as 0, and writes to it change neither word.
- R7: A register write takes effect from the clock after it is written. The step decision in the write cycle uses the old pair.
- R8: A correction tick clears the fractional accumulator at that clock edge. A step decided in the same cycle still advances the count, and later steps follow from a zero residue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| corr_tick | input | 1 | Correction tick, clears the fractional residue |
| count | output | 64 | Free-running time count |

## Verification
The correction tick and a step can fall in the same cycle. The bench first aligns the residue with one tick, using the pair 2/5. It then fires a second tick exactly on the third clock, where a step is due. It judges that the count still advances on that clock, and that the next step comes three clocks later rather than two, which shows the residue of 1 was dropped. A register write and a step decision also coincide. The bench changes a slow pair to a saturating one and checks that the write cycle still used the old pair.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  // register selector decoded from the byte offset
  typedef enum logic [1:0] {
    RSEL_NUM  = 2'd0,
    RSEL_DEN  = 2'd1,
    RSEL_NONE = 2'd2
  } rsel_e;

  // outcome of one incrementer evaluation
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_FRAC  = 2'd1,
    STEP_EVERY = 2'd2
  } step_kind_e;
endpackage

// File: rtl/rfc_regs.sv
module rfc_regs
  import rfc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12,
  parameter logic [ADDR_W-1:0] NUM_OFFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFFS = 8'h14,
  parameter logic [DATA_W-1:0] NUM_RST = 32'd4,
  parameter logic [DATA_W-1:0] DEN_RST = 32'd25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] num_word,
  output logic [DATA_W-1:0] den_word,
  output logic [FRAC_W-1:0] num_f,
  output logic [FRAC_W-1:0] den_f
);
  localparam int NREG = 2;
  localparam logic [ADDR_W-1:0] OFFS [NREG] = '{NUM_OFFS, DEN_OFFS};
  localparam logic [DATA_W-1:0] RSTV [NREG] = '{NUM_RST, DEN_RST};

  logic [NREG-1:0]   hit;
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = (addr == OFFS[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= RSTV[i];
    end else if (wr) begin
      for (int i = 0; i < NREG; i++)
        if (hit[i]) regs[i] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_mux = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign num_word = regs[int'(RSEL_NUM)];
  assign den_word = regs[int'(RSEL_DEN)];
  assign num_f    = num_word[FRAC_W-1:0];
  assign den_f    = den_word[FRAC_W-1:0];
endmodule

// File: rtl/rfc_frac_acc.sv
module rfc_frac_acc
  import rfc_pkg::*;
#(
  parameter int FRAC_W = 12,
  localparam int ACC_W = FRAC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  input  logic             corr,
  output logic             step,
  output logic [ACC_W-1:0] acc
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum, den_x;
  step_kind_e       kind;

  always_comb begin
    sum   = {1'b0, acc_q} + SUM_W'(num);
    den_x = SUM_W'(den);
    if (den == '0)               kind = STEP_HOLD;
    else if (num >= den)         kind = STEP_EVERY;
    else if (sum >= den_x)       kind = STEP_FRAC;
    else                         kind = STEP_HOLD;
  end

  always_comb begin
    unique case (kind)
      STEP_EVERY: acc_d = '0;
      STEP_FRAC:  acc_d = ACC_W'(sum - den_x);
      default:    acc_d = (den == '0) ? acc_q : ACC_W'(sum);
    endcase
    if (corr) acc_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign step = (kind != STEP_HOLD);
  assign acc  = acc_q;
endmodule

// File: rtl/rfc_count.sv
module rfc_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count = cnt_q;
endmodule

// File: rtl/rfc_counter.sv
module rfc_counter #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12,
  parameter int CNT_W  = 64,
  parameter logic [ADDR_W-1:0] NUM_OFFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFFS = 8'h14,
  parameter logic [DATA_W-1:0] NUM_RST  = 32'd4,
  parameter logic [DATA_W-1:0] DEN_RST  = 32'd25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              corr_tick,
  output logic [CNT_W-1:0]  count
);
  localparam int ACC_W = FRAC_W + 1;

  logic [DATA_W-1:0] num_word, den_word;
  logic [FRAC_W-1:0] num_f, den_f;
  logic              step;
  logic [ACC_W-1:0]  acc;

  rfc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W),
    .NUM_OFFS(NUM_OFFS), .DEN_OFFS(DEN_OFFS),
    .NUM_RST(NUM_RST), .DEN_RST(DEN_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .num_word(num_word), .den_word(den_word),
    .num_f(num_f), .den_f(den_f)
  );

  rfc_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .num(num_f), .den(den_f), .corr(corr_tick),
    .step(step), .acc(acc)
  );

  rfc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .count(count)
  );
endmodule

// File: rtl/rfc_counter_chk.sv
module rfc_counter_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12,
  parameter int CNT_W  = 64,
  parameter logic [ADDR_W-1:0] NUM_OFFS = 8'h10,
  localparam int ACC_W = FRAC_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  count,
  input logic [FRAC_W-1:0] num_f,
  input logic [FRAC_W-1:0] den_f,
  input logic [ACC_W-1:0]  acc,
  input logic              corr_tick,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] num_word
);
  assert_step_max_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count - $past(count)) <= CNT_W'(1));

  assert_hold_den_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (den_f == '0) |=> (count == $past(count)));

  assert_every_clock_R5: assert property (@(posedge clk) disable iff (rst)
    (den_f != '0 && num_f >= den_f) |=> (count == $past(count) + CNT_W'(1)));

  assert_residue_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (den_f != '0 && num_f < den_f && acc < {1'b0, den_f})
      |=> (acc < {1'b0, $past(den_f)}));

  assert_corr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    corr_tick |=> (acc == '0));

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == NUM_OFFS) |=> (num_word == $past(reg_wdata)));
endmodule

bind rfc_counter rfc_counter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W),
  .NUM_OFFS(NUM_OFFS)
) u_chk (
  .clk(clk), .rst(rst), .count(count), .num_f(num_f), .den_f(den_f),
  .acc(acc), .corr_tick(corr_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .num_word(num_word)
);

// File: tb/rfc_counter_tb.sv
`timescale 1ns/1ps
module rfc_counter_tb;
  localparam logic [7:0] A_NUM = 8'h10;
  localparam logic [7:0] A_DEN = 8'h14;
  localparam int NV = 8;
  localparam logic [11:0] VNUM [NV] = '{12'd64, 12'd768, 12'd8, 12'd192,
                                       12'd384, 12'd256, 12'd4, 12'd75};
  localparam logic [11:0] VDEN [NV] = '{12'd125, 12'd1625, 12'd25, 12'd625,
                                       12'd1625, 12'd1125, 12'd25, 12'd244};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        corr_tick = 1'b0;
  logic [63:0] count;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rfc_counter u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .corr_tick(corr_tick),
    .count(count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic tick;
    corr_tick = 1'b1;
    @(negedge clk);
    corr_tick = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] c0;
    logic [31:0] wn, wd;
    repeat (4) @(negedge clk);
    chk("R1 count in reset", count, 64'd0);
    rst = 1'b0;
    rd_reg(A_NUM, rd); chk("R1 numerator reset", 64'(rd), 64'd4);
    rd_reg(A_DEN, rd); chk("R1 denominator reset", 64'(rd), 64'd25);

    // R2 and R6: vector table of rate pairs with distinct upper fields
    for (int i = 0; i < NV; i++) begin
      wn = {20'(i * 20'h1357 + 20'h0F0F1), VNUM[i]};
      wd = {20'(i * 20'h2468 + 20'hA0A03), VDEN[i]};
      wr_reg(A_DEN, wd);
      wr_reg(A_NUM, wn);
      repeat (2) @(negedge clk);
      c0 = count;
      repeat (int'(VDEN[i])) @(negedge clk);
      chk("R2 advance over one denominator window", count - c0, 64'(VNUM[i]));
      rd_reg(A_NUM, rd); chk("R6 numerator readback", 64'(rd), 64'(wn));
      rd_reg(A_DEN, rd); chk("R6 denominator readback", 64'(rd), 64'(wd));
    end

    // R6: unmapped offset
    wr_reg(8'h18, 32'hDEAD_BEEF);
    rd_reg(8'h18, rd); chk("R6 unmapped reads zero", 64'(rd), 64'd0);
    rd_reg(A_NUM, rd); chk("R6 unmapped write leaves numerator", 64'(rd), 64'(wn));
    rd_reg(A_DEN, rd); chk("R6 unmapped write leaves denominator", 64'(rd), 64'(wd));

    // R4: zero denominator field with upper bits set
    wr_reg(A_DEN, 32'hFFFF_F000);
    @(negedge clk);
    c0 = count;
    repeat (20) @(negedge clk);
    chk("R4 count holds with zero denominator", count, c0);

    // R5 and R3: numerator above and equal to denominator
    wr_reg(A_DEN, 32'd3);
    wr_reg(A_NUM, 32'd7);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      c0 = count;
      @(negedge clk);
      chk("R5 R3 one step per clock", count - c0, 64'd1);
    end
    wr_reg(A_DEN, 32'd5);
    wr_reg(A_NUM, 32'd5);
    @(negedge clk);
    c0 = count;
    repeat (10) @(negedge clk);
    chk("R5 equal pair steps every clock", count - c0, 64'd10);

    // R7: write lands after the cycle it is written in
    wr_reg(A_NUM, 32'd1);
    wr_reg(A_DEN, 32'd1000);
    tick();
    c0 = count;
    wr_reg(A_NUM, 32'd1000);
    chk("R7 write cycle uses old pair", count, c0);
    @(negedge clk);
    chk("R7 new pair from next clock", count, c0 + 64'd1);

    // R8: correction tick, alone and on a step clock (pair 2/5)
    wr_reg(A_DEN, 32'd5);
    wr_reg(A_NUM, 32'd2);
    tick();
    c0 = count;
    repeat (2) @(negedge clk);
    chk("R8 no step two clocks after tick", count, c0);
    tick();
    chk("R8 step kept on tick clock", count, c0 + 64'd1);
    repeat (2) @(negedge clk);
    chk("R8 residue dropped, no early step", count, c0 + 64'd1);
    @(negedge clk);
    chk("R8 step three clocks after tick", count, c0 + 64'd2);

    finish_run();
  end
endmodule